// File: doc/BRIEF.md
# Port Block Transfer Sequencer

This block moves a run of bytes between a single I/O port and memory without any processor involvement per byte. On a start pulse it loads three working registers: an 8-bit port number, an 8-bit byte count and a 16-bit memory pointer. It also latches three run options: the transfer direction, the pointer step direction and single or repeat operation. Each byte then takes exactly two clock cycles. The first cycle reads the source and latches the byte. The second cycle writes that byte to the sink, then steps the pointer and decrements the count.

The controller is a four-state machine. IDLE waits for start, and the LOAD transition moves it to FETCH. FETCH always moves to STORE. From STORE, the NEXT transition returns to FETCH when repeat is selected and the byte just moved was not the last one. Otherwise the LAST transition goes to FINISH. FINISH raises done for one cycle and the RETIRE transition returns to IDLE. The current count and pointer are visible on ports, so software or a parent block can resume or inspect a run.

Top module: `port_block_xfer`

## Requirements
- R1: After reset the block is idle. busy, done, io_rd, io_wr, mem_rd and mem_wr are all 0, and count_now and addr_now are 0.
- R2: On an accepted start, port_sel is loaded into the port register. io_port shows that value for the whole run, whatever port_sel does later.
- R3: With dir_in=1 (input), each byte is read from the port with io_rd in one cycle. The same byte is written to memory at addr_now with mem_wr in the next cycle.
- R4: With dir_in=0 (output), each byte is read from memory at addr_now with mem_rd in one cycle. The same byte is written to the port with io_wr in the next cycle.
- R5: After each byte the 16-bit pointer steps by one, downward when step_down=1 and upward when step_down=0. It wraps modulo 65536.
- R6: After each byte the 8-bit count decreases by one. With repeat_mode=1, bytes keep moving until the count reaches 0.
- R7: With repeat_mode=0, exactly one byte moves per start, and the count ends at its starting value minus one.
- R8: A starting count of 0 in repeat mode moves 256 bytes. The count wraps to 0xFF and goes on until it reaches 0.
- R9: No cycle has an I/O strobe (io_rd or io_wr) together with a memory strobe (mem_rd or mem_wr).
- R10: done is high for exactly one cycle. It is seen 2n+1 cycles after the edge that accepts a start, where n is the number of bytes moved.
- R11: A start pulse while busy is ignored. The running transfer's port, count, pointer, options and data are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, sampled in IDLE |
| dir_in | input | 1 | 1: port to memory, 0: memory to port |
| step_down | input | 1 | 1: pointer decrements, 0: increments |
| repeat_mode | input | 1 | 1: run until count is zero, 0: one byte |
| port_sel | input | 8 | Port number loaded at start |
| count_sel | input | 8 | Byte count loaded at start (0 means 256 in repeat) |
| addr_sel | input | 16 | Memory pointer loaded at start |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid in the mem_rd cycle |
| io_port | output | 8 | Port number of the current run |
| io_rd | output | 1 | Port read strobe |
| io_wr | output | 1 | Port write strobe |
| io_wdata | output | 8 | Port write data |
| io_rdata | input | 8 | Port read data, valid in the io_rd cycle |
| busy | output | 1 | High in FETCH and STORE |
| done | output | 1 | One-cycle end-of-run pulse |
| count_now | output | 8 | Current count register |
| addr_now | output | 16 | Current pointer register |

## Verification
Some faults corrupt internal state without breaking the strobes. A wrong pointer step writes bytes to shifted addresses in the bench's memory image, or emits them in the wrong order on the port. addr_now also differs from the computed value right after done. A wrong count or a wrong end test changes how many bytes move. It also moves the done pulse away from cycle 2n+1, which shows at once in the run. The 256-byte case and a start pulse in the middle of a run then show whether the count wraps correctly and whether the port, count, pointer and options are held for the whole run.

// File: rtl/port_block_xfer_pkg.sv
package port_block_xfer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_STORE  = 2'd2,
        ST_FINISH = 2'd3
    } pbx_state_t;

    typedef struct packed {
        logic to_mem;
        logic downward;
        logic repeat_run;
    } pbx_opts_t;

endpackage

// File: rtl/pbx_pointer.sv
module pbx_pointer #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    input  logic          down,
    output logic [AW-1:0] ptr
);
    localparam logic [AW-1:0] ONE = AW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (step) begin
            ptr <= down ? ptr - ONE : ptr + ONE;
        end
    end

    // R5
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (ptr == ($past(down) ? $past(ptr) - ONE : $past(ptr) + ONE)));
endmodule

// File: rtl/pbx_counter.sv
module pbx_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic [CW-1:0] cnt,
    output logic          last
);
    localparam logic [CW-1:0] ONE = CW'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec) begin
            cnt <= cnt - ONE;
        end
    end

    assign last = (cnt == ONE);

    // R6 R8
    cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |=> (cnt == $past(cnt) - ONE));
endmodule

// File: rtl/pbx_ctrl.sv
module pbx_ctrl
    import port_block_xfer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       repeat_run,
    input  logic       last,
    output pbx_state_t state,
    output logic       load,
    output logic       fetch,
    output logic       store,
    output logic       busy,
    output logic       done
);
    pbx_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = ST_FETCH;
            ST_FETCH:  nxt = ST_STORE;
            ST_STORE:  nxt = (repeat_run && !last) ? ST_FETCH : ST_FINISH;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        load  = 1'b0;
        fetch = 1'b0;
        store = 1'b0;
        busy  = 1'b0;
        done  = 1'b0;
        unique case (state)
            ST_IDLE:   load = start;
            ST_FETCH:  begin fetch = 1'b1; busy = 1'b1; end
            ST_STORE:  begin store = 1'b1; busy = 1'b1; end
            ST_FINISH: done = 1'b1;
            default:   ;
        endcase
    end

    // R3 R4
    fetch_then_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch |=> store);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    idle_only_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !load);
endmodule

// File: rtl/port_block_xfer.sv
module port_block_xfer
    import port_block_xfer_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 8,
    parameter int PW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          dir_in,
    input  logic          step_down,
    input  logic          repeat_mode,
    input  logic [PW-1:0] port_sel,
    input  logic [CW-1:0] count_sel,
    input  logic [AW-1:0] addr_sel,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic [PW-1:0] io_port,
    output logic          io_rd,
    output logic          io_wr,
    output logic [DW-1:0] io_wdata,
    input  logic [DW-1:0] io_rdata,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] count_now,
    output logic [AW-1:0] addr_now
);
    pbx_state_t    state;
    pbx_opts_t     opts_q;
    logic [PW-1:0] port_q;
    logic [DW-1:0] byte_q;
    logic          load, fetch, store, last;

    pbx_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .repeat_run (opts_q.repeat_run),
        .last       (last),
        .state      (state),
        .load       (load),
        .fetch      (fetch),
        .store      (store),
        .busy       (busy),
        .done       (done)
    );

    pbx_pointer #(.AW(AW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (addr_sel),
        .step     (store),
        .down     (opts_q.downward),
        .ptr      (addr_now)
    );

    pbx_counter #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (count_sel),
        .dec      (store),
        .cnt      (count_now),
        .last     (last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_q <= '0;
            opts_q <= '0;
            byte_q <= '0;
        end else begin
            if (load) begin
                port_q <= port_sel;
                opts_q <= '{to_mem: dir_in, downward: step_down, repeat_run: repeat_mode};
            end
            if (fetch) begin
                byte_q <= opts_q.to_mem ? io_rdata : mem_rdata;
            end
        end
    end

    assign io_rd     = fetch &  opts_q.to_mem;
    assign mem_rd    = fetch & ~opts_q.to_mem;
    assign mem_wr    = store &  opts_q.to_mem;
    assign io_wr     = store & ~opts_q.to_mem;
    assign mem_addr  = addr_now;
    assign io_port   = port_q;
    assign mem_wdata = byte_q;
    assign io_wdata  = byte_q;

    // R9
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((io_rd || io_wr) && (mem_rd || mem_wr)));

    // R2
    port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fetch) |-> $stable(io_port));

    // R3 R4
    byte_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd || mem_rd) |=> $stable(addr_now));
endmodule

// File: tb/port_block_xfer_tb.sv
module port_block_xfer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, dir_in = 1'b0, step_down = 1'b0, repeat_mode = 1'b0;
    logic [7:0]  port_sel = '0, count_sel = '0;
    logic [15:0] addr_sel = '0;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr, io_rd, io_wr, busy, done;
    logic [7:0]  mem_wdata, mem_rdata, io_port, io_wdata, io_rdata, count_now;
    logic [15:0] addr_now;

    always #4 clk = ~clk;

    port_block_xfer u_dut (.*);

    int total = 0, bad = 0;
    int cyc = 0, seq = 0, overlap = 0, done_n = 0, done_cyc = 0, io_n = 0;
    logic pend = 1'b0;
    logic [7:0] bmem [256];
    logic [7:0] exp_mem [256];
    logic [7:0] log_d [512];
    logic [7:0] log_p [512];

    function automatic logic [7:0] init_val(int a);
        return 8'((a * 5) + 3);
    endfunction
    function automatic logic [7:0] port_val(int k, logic [7:0] p);
        return 8'((k * 37) + int'(p) + 11);
    endfunction

    assign mem_rdata = bmem[mem_addr[7:0]];
    assign io_rdata  = port_val(seq, io_port);

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (pend) begin seq = seq + 1; pend = 1'b0; end
        if (io_rd) pend = 1'b1;
        if (mem_wr) bmem[mem_addr[7:0]] = mem_wdata;
        if (io_wr) begin
            if (io_n < 512) begin log_d[io_n] = io_wdata; log_p[io_n] = io_port; end
            io_n = io_n + 1;
        end
        if ((io_rd || io_wr) && (mem_rd || mem_wr)) overlap = overlap + 1;
        if (done) begin done_n = done_n + 1; done_cyc = cyc; end
        if (cyc > 150000) begin
            bad = bad + 1; total = total + 1;
            $display("FAIL watchdog: act=%0d exp<=150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic run(input bit din, input bit dn, input bit rpt, input logic [7:0] p,
                       input logic [7:0] c, input logic [15:0] a, input bit poke);
        int n, s0, c0, waited, errs;
        logic [15:0] ea;
        n = rpt ? ((c == 0) ? 256 : int'(c)) : 1;
        for (int i = 0; i < 256; i++) begin bmem[i] = init_val(i); exp_mem[i] = init_val(i); end
        @(negedge clk); #1;
        io_n = 0; done_n = 0; overlap = 0; s0 = seq; c0 = cyc;
        dir_in = din; step_down = dn; repeat_mode = rpt;
        port_sel = p; count_sel = c; addr_sel = a; start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            #1; start = 1'b1; dir_in = ~din; step_down = ~dn; repeat_mode = 1'b0;
            port_sel = ~p; count_sel = 8'd9; addr_sel = ~a;
            @(negedge clk); #1; start = 1'b0;
        end
        waited = 0;
        while (done_n == 0 && waited < 2000) begin @(negedge clk); waited++; end
        repeat (3) @(negedge clk);
        #1;
        chk(done_n == 1, "R10 done count", done_n, 1);
        chk(done_cyc - c0 == 2 * n + 1, "R10 done timing", done_cyc - c0, 2 * n + 1);
        chk(overlap == 0, "R9 strobe overlap", overlap, 0);
        ea = dn ? a - 16'(n) : a + 16'(n);
        chk(addr_now == ea, "R5 final pointer", int'(addr_now), int'(ea));
        chk(count_now == 8'(c - 8'(n)), rpt ? (c == 0 ? "R8 count wrap" : "R6 final count") : "R7 single count",
            int'(count_now), int'(8'(c - 8'(n))));
        errs = 0;
        if (din) begin
            for (int k = 0; k < n; k++) begin
                ea = dn ? a - 16'(k) : a + 16'(k);
                exp_mem[ea[7:0]] = port_val(s0 + k, p);
            end
            for (int i = 0; i < 256; i++) if (bmem[i] !== exp_mem[i]) errs++;
            chk(errs == 0, poke ? "R11 input data" : "R3 input data", errs, 0);
            chk(io_n == 0, "R3 no port writes", io_n, 0);
        end else begin
            chk(io_n == n, "R4 byte count", io_n, n);
            for (int k = 0; k < n && k < io_n; k++) begin
                ea = dn ? a - 16'(k) : a + 16'(k);
                if (log_d[k] !== init_val(int'(ea[7:0]))) errs++;
                if (log_p[k] !== p) errs++;
            end
            chk(errs == 0, poke ? "R11 output data/R2 port" : "R4 output data/R2 port", errs, 0);
            for (int i = 0; i < 256; i++) if (bmem[i] !== exp_mem[i]) errs++;
            chk(errs == 0, "R4 memory untouched", errs, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0, "R1 reset busy/done", int'({busy, done}), 0);
        chk({io_rd, io_wr, mem_rd, mem_wr} == 4'b0, "R1 reset strobes",
            int'({io_rd, io_wr, mem_rd, mem_wr}), 0);
        chk(count_now == 0 && addr_now == 0, "R1 reset regs", int'(count_now), 0);
        #1 rst_n = 1'b1;
        run(1, 0, 1, 8'h3C, 8'd3,   16'h1240, 0);
        run(1, 1, 1, 8'h81, 8'd4,   16'h0001, 0);
        run(0, 0, 1, 8'h07, 8'd5,   16'hFFFE, 0);
        run(0, 1, 0, 8'h55, 8'd7,   16'h2010, 0);
        run(1, 0, 0, 8'hA2, 8'd1,   16'h00F0, 0);
        run(1, 0, 1, 8'h10, 8'd0,   16'h3300, 0);
        run(0, 1, 1, 8'hE9, 8'd0,   16'h7780, 0);
        run(0, 0, 1, 8'h44, 8'd12,  16'h0100, 1);
        run(1, 1, 1, 8'h6D, 8'd10,  16'h4008, 1);
        for (int dd = 0; dd < 2; dd++)
            for (int cc = 1; cc <= 4; cc++)
                run(dd[0], cc[0], 1, 8'(cc * 17), 8'(cc), 16'(cc * 300), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule